// File: doc/BRIEF.md
# SD Host Status and Interrupt Controller

This block holds the present-state flags of an SD host controller and builds its interrupt status word from them. The command and data engines report what they see: a write to the command register, a response arriving, data line activity, read activity, buffer space and buffer data, card presence, card interrupt level and error pulses. The block keeps the command and data inhibit flags and turns chosen transitions of the present-state flags into latched status bits. It also holds an error summary bit and drives one interrupt line.

Software sees two masks. The status-enable mask decides whether an event is latched at all. The signal-enable mask decides which latched bits reach the interrupt line. Latched bits are cleared by writing ones to them. A software "reset all" clears the command inhibit flag and every latched bit. The card presence and card stability flags keep tracking their inputs through such a reset.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: `pres_o` is a registered copy of the flags, one cycle after the inputs. Bit 0 is command inhibit. Bit 1 is data inhibit, the OR of bits 2 and 3. Bit 2 is data line active, bit 3 read active, bit 4 buffer writable, bit 5 buffer readable, bit 6 card present, bit 7 card stable and bit 8 the card interrupt level. After `rst` every flag is 0.
- R2: `cmd_wr` sets command inhibit at the next edge and takes precedence. `rsp_done` without `rsp_conflict` clears command inhibit. That 1-to-0 change of command inhibit sets status bit 0, command complete.
- R3: A 1-to-0 change of data inhibit sets status bit 1, transfer complete.
- R4: Card present going 0-to-1 sets status bit 6. Card present going 1-to-0 sets status bit 7.
- R5: Buffer writable going 0-to-1 sets status bit 4. Buffer readable going 0-to-1 sets status bit 5.
- R6: With `stat_wr` high, a 1 in `stat_wdata` clears the matching writable status bit and a 0 leaves it unchanged. An event in the same cycle as its clear wins, so the bit stays 1.
- R7: Status bit 8 follows `card_irq` ANDed with `stat_en[8]` every cycle. Writes do not change it.
- R8: Pulse `err_evt[i]` sets status bit 16+i. Bits 2, 3, 9 to 14, 30 and 31 always read 0.
- R9: Status bit 15 is 1 exactly when any of bits 16 to 29 is 1. Writes do not change it.
- R10: `irq_o` updates at the same edge as `status_o`. It is the OR over all bits of the new status ANDed with the `sig_en` value sampled at that edge.
- R11: An event whose `stat_en` bit is 0 is dropped. A later enable does not recover it.
- R12: `rsp_done` together with `rsp_conflict` leaves command inhibit set and does not set status bit 0.
- R13: `sw_rst` clears command inhibit and all latched status bits, and events in that cycle are dropped. Card present and card stable keep following their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset-all pulse |
| cmd_wr | input | 1 | Command register written |
| rsp_done | input | 1 | Command response received |
| rsp_conflict | input | 1 | The response belongs to a command that could not be issued |
| dat_line_act | input | 1 | Data line active level |
| rd_xfer_act | input | 1 | Read transfer active level |
| buf_rd_ok | input | 1 | Buffer holds a readable block |
| buf_wr_ok | input | 1 | Buffer has space for a block |
| card_in | input | 1 | Card present level |
| card_stable | input | 1 | Card detect stable level |
| card_irq | input | 1 | Card interrupt level |
| err_evt | input | ERR_W | Error event pulses, bit i maps to status bit 16+i |
| stat_wr | input | 1 | Write-one-to-clear strobe |
| stat_wdata | input | 32 | Clear pattern |
| stat_en | input | 32 | Status-enable mask |
| sig_en | input | 32 | Signal-enable mask |
| pres_o | output | 9 | Present-state flags |
| status_o | output | 32 | Interrupt status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status event that lands in the same cycle as the write that clears its bit. A second hard case is a response flagged as a conflict while command inhibit is set. Both need pulses lined up with a level change in the cycle before. Directed sequences place the transition, the clear and the mask change in one chosen cycle. A long random phase then mixes slow level toggles, pulses, clears and mask changes against a cycle-by-cycle reference model.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int STAT_W = 32;
  localparam int PRES_W = 9;
  localparam int ERR_LSB = 16;
  localparam int ERR_MAX = STAT_W - ERR_LSB;

  localparam int B_CMD_DONE  = 0;
  localparam int B_XFER_DONE = 1;
  localparam int B_WR_RDY    = 4;
  localparam int B_RD_RDY    = 5;
  localparam int B_INSERT    = 6;
  localparam int B_REMOVE    = 7;
  localparam int B_CARD_INT  = 8;
  localparam int B_ERR_SUM   = 15;

  localparam int P_CMD_INH  = 0;
  localparam int P_DAT_INH  = 1;
  localparam int P_DAT_LINE = 2;
  localparam int P_RD_ACT   = 3;
  localparam int P_BUF_WR   = 4;
  localparam int P_BUF_RD   = 5;
  localparam int P_CARD_IN  = 6;
  localparam int P_CARD_STB = 7;
  localparam int P_CARD_INT = 8;

  function automatic logic [STAT_W-1:0] w1c_mask(input int n_err);
    logic [STAT_W-1:0] m;
    m = '0;
    m[B_CMD_DONE]  = 1'b1;
    m[B_XFER_DONE] = 1'b1;
    m[B_WR_RDY]    = 1'b1;
    m[B_RD_RDY]    = 1'b1;
    m[B_INSERT]    = 1'b1;
    m[B_REMOVE]    = 1'b1;
    for (int i = 0; i < n_err; i++) m[ERR_LSB + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sdh_pres_track.sv
module sdh_pres_track
  import sdh_irq_pkg::*;
#(
  parameter int ERR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              cmd_wr,
  input  logic              rsp_done,
  input  logic              rsp_conflict,
  input  logic              dat_line_act,
  input  logic              rd_xfer_act,
  input  logic              buf_rd_ok,
  input  logic              buf_wr_ok,
  input  logic              card_in,
  input  logic              card_stable,
  input  logic              card_irq,
  input  logic [ERR_W-1:0]  err_evt,
  output logic [PRES_W-1:0] pres_o,
  output logic [STAT_W-1:0] evt_o
);
  logic cinh_q, dl_q, rd_q, bw_q, br_q, ci_q, cs_q, cirq_q;
  logic rsp_ok, dinh_now;

  assign rsp_ok   = rsp_done && !rsp_conflict;
  assign dinh_now = dat_line_act || rd_xfer_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cinh_q <= 1'b0;
      dl_q   <= 1'b0;
      rd_q   <= 1'b0;
      bw_q   <= 1'b0;
      br_q   <= 1'b0;
      ci_q   <= 1'b0;
      cs_q   <= 1'b0;
      cirq_q <= 1'b0;
    end else begin
      if (sw_rst)      cinh_q <= 1'b0;
      else if (cmd_wr) cinh_q <= 1'b1;
      else if (rsp_ok) cinh_q <= 1'b0;
      dl_q   <= dat_line_act;
      rd_q   <= rd_xfer_act;
      bw_q   <= buf_wr_ok;
      br_q   <= buf_rd_ok;
      ci_q   <= card_in;
      cs_q   <= card_stable;
      cirq_q <= card_irq;
    end
  end

  always_comb begin
    pres_o             = '0;
    pres_o[P_CMD_INH]  = cinh_q;
    pres_o[P_DAT_INH]  = dl_q | rd_q;
    pres_o[P_DAT_LINE] = dl_q;
    pres_o[P_RD_ACT]   = rd_q;
    pres_o[P_BUF_WR]   = bw_q;
    pres_o[P_BUF_RD]   = br_q;
    pres_o[P_CARD_IN]  = ci_q;
    pres_o[P_CARD_STB] = cs_q;
    pres_o[P_CARD_INT] = cirq_q;
  end

  always_comb begin
    evt_o                    = '0;
    evt_o[B_CMD_DONE]        = cinh_q && !cmd_wr && rsp_ok;
    evt_o[B_XFER_DONE]       = (dl_q || rd_q) && !dinh_now;
    evt_o[B_WR_RDY]          = !bw_q && buf_wr_ok;
    evt_o[B_RD_RDY]          = !br_q && buf_rd_ok;
    evt_o[B_INSERT]          = !ci_q && card_in;
    evt_o[B_REMOVE]          = ci_q && !card_in;
    evt_o[ERR_LSB +: ERR_W]  = err_evt;
  end
endmodule

// File: rtl/sdh_stat_word.sv
module sdh_stat_word
  import sdh_irq_pkg::*;
#(
  parameter int ERR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              card_irq,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic [STAT_W-1:0] stat_en,
  input  logic [STAT_W-1:0] sig_en,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [STAT_W-1:0] W1C = w1c_mask(ERR_W);

  logic [STAT_W-1:0] st_q, lat_d, st_d;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (W1C[i]) begin : g_w1c
      assign lat_d[i] = !sw_rst &&
                        ((st_q[i] && !(stat_wr && stat_wdata[i])) ||
                         (evt_i[i] && stat_en[i]));
    end else begin : g_fixed
      assign lat_d[i] = 1'b0;
    end
  end

  always_comb begin
    st_d             = lat_d;
    st_d[B_CARD_INT] = card_irq && stat_en[B_CARD_INT];
    st_d[B_ERR_SUM]  = |lat_d[ERR_LSB +: ERR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_o <= |(st_d & sig_en);
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_irq_pkg::*;
#(
  parameter int ERR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              cmd_wr,
  input  logic              rsp_done,
  input  logic              rsp_conflict,
  input  logic              dat_line_act,
  input  logic              rd_xfer_act,
  input  logic              buf_rd_ok,
  input  logic              buf_wr_ok,
  input  logic              card_in,
  input  logic              card_stable,
  input  logic              card_irq,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  input  logic [31:0]       stat_en,
  input  logic [31:0]       sig_en,
  output logic [8:0]        pres_o,
  output logic [31:0]       status_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] evt;

  sdh_pres_track #(.ERR_W(ERR_W)) u_track (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cmd_wr(cmd_wr),
    .rsp_done(rsp_done), .rsp_conflict(rsp_conflict),
    .dat_line_act(dat_line_act), .rd_xfer_act(rd_xfer_act),
    .buf_rd_ok(buf_rd_ok), .buf_wr_ok(buf_wr_ok),
    .card_in(card_in), .card_stable(card_stable), .card_irq(card_irq),
    .err_evt(err_evt), .pres_o(pres_o), .evt_o(evt)
  );

  sdh_stat_word #(.ERR_W(ERR_W)) u_stat (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .evt_i(evt), .card_irq(card_irq),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_en(stat_en),
    .sig_en(sig_en), .status_o(status_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/sdh_irq_ctrl_chk.sv
module sdh_irq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        sw_rst,
  input logic        cmd_wr,
  input logic        rsp_done,
  input logic        rsp_conflict,
  input logic [31:0] stat_en,
  input logic [31:0] sig_en,
  input logic [8:0]  pres_o,
  input logic [31:0] status_o,
  input logic        irq_o
);
  a_r2_inhibit_set: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !sw_rst) |=> pres_o[0]);

  a_r2_complete_on_fall: assert property (@(posedge clk) disable iff (rst)
    (pres_o[0] && rsp_done && !rsp_conflict && !cmd_wr && !sw_rst && stat_en[0])
    |=> (!pres_o[0] && status_o[0]));

  a_r12_conflict_holds: assert property (@(posedge clk) disable iff (rst)
    (pres_o[0] && rsp_done && rsp_conflict && !sw_rst) |=> pres_o[0]);

  a_r3_xfer_done: assert property (@(posedge clk) disable iff (rst)
    (pres_o[1] && stat_en[1] && !sw_rst) |=> (pres_o[1] || status_o[1]));

  a_r9_summary: assert property (@(posedge clk) disable iff (rst)
    status_o[15] == (|status_o[29:16]));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (status_o & 32'hC000_7E0C) == 32'h0);

  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (|(status_o & $past(sig_en)))));

  a_r13_sw_clear: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!pres_o[0] && status_o[29:16] == 14'h0 && status_o[7:0] == 8'h0));
endmodule

bind sdh_irq_ctrl sdh_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .cmd_wr(cmd_wr),
  .rsp_done(rsp_done), .rsp_conflict(rsp_conflict),
  .stat_en(stat_en), .sig_en(sig_en),
  .pres_o(pres_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/sdh_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sdh_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_rst = 0, cmd_wr = 0, rsp_done = 0, rsp_conflict = 0;
  logic dat_line_act = 0, rd_xfer_act = 0, buf_rd_ok = 0, buf_wr_ok = 0;
  logic card_in = 0, card_stable = 0, card_irq = 0;
  logic [13:0] err_evt = '0;
  logic stat_wr = 0;
  logic [31:0] stat_wdata = '0, stat_en = '1, sig_en = '0;
  logic [8:0] pres_o;
  logic [31:0] status_o;
  logic irq_o;

  int n_cmp = 0, n_bad = 0;
  bit started = 0, done = 0;
  string phase = "reset";

  always #2 clk = ~clk;

  sdh_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cmd_wr(cmd_wr),
    .rsp_done(rsp_done), .rsp_conflict(rsp_conflict),
    .dat_line_act(dat_line_act), .rd_xfer_act(rd_xfer_act),
    .buf_rd_ok(buf_rd_ok), .buf_wr_ok(buf_wr_ok),
    .card_in(card_in), .card_stable(card_stable), .card_irq(card_irq),
    .err_evt(err_evt), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_en(stat_en), .sig_en(sig_en),
    .pres_o(pres_o), .status_o(status_o), .irq_o(irq_o)
  );

  // Reference model state
  bit m_cinh, m_dl, m_rd, m_bw, m_br, m_ci, m_cs, m_cirq, m_irq;
  bit [31:0] m_st;
  localparam bit [31:0] WMASK = 32'h3FFF_00F3;

  always @(posedge clk) begin
    bit [31:0] ev, nx, clr;
    bit ninh;
    started <= 1'b1;
    if (rst) begin
      {m_cinh, m_dl, m_rd, m_bw, m_br, m_ci, m_cs, m_cirq, m_irq} = '0;
      m_st = '0;
    end else begin
      ev = '0;
      if (sw_rst) ninh = 0;
      else if (cmd_wr) ninh = 1;
      else if (rsp_done && !rsp_conflict) ninh = 0;
      else ninh = m_cinh;
      if (m_cinh && !ninh) ev[0] = 1;
      if ((m_dl || m_rd) && !(dat_line_act || rd_xfer_act)) ev[1] = 1;
      if (!m_bw && buf_wr_ok) ev[4] = 1;
      if (!m_br && buf_rd_ok) ev[5] = 1;
      if (!m_ci && card_in) ev[6] = 1;
      if (m_ci && !card_in) ev[7] = 1;
      for (int i = 0; i < 14; i++) if (err_evt[i]) ev[16+i] = 1;
      clr = stat_wr ? stat_wdata : 32'h0;
      if (sw_rst) nx = '0;
      else nx = ((m_st & ~clr) | (ev & stat_en)) & WMASK;
      nx[8] = card_irq && stat_en[8];
      nx[15] = (nx[29:16] != 0);
      m_irq = (nx & sig_en) != 0;
      m_st = nx;
      m_cinh = ninh;
      m_dl = dat_line_act; m_rd = rd_xfer_act;
      m_bw = buf_wr_ok; m_br = buf_rd_ok;
      m_ci = card_in; m_cs = card_stable; m_cirq = card_irq;
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t: actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("R1 present", {23'h0, pres_o},
          {23'h0, m_cirq, m_cs, m_ci, m_br, m_bw, m_rd, m_dl, (m_dl | m_rd), m_cinh});
      cmp("R2 cmd complete", {31'h0, status_o[0]}, {31'h0, m_st[0]});
      cmp("R3 xfer complete", {31'h0, status_o[1]}, {31'h0, m_st[1]});
      cmp("R5 buffer ready", {30'h0, status_o[5:4]}, {30'h0, m_st[5:4]});
      cmp("R4 card insert/remove", {30'h0, status_o[7:6]}, {30'h0, m_st[7:6]});
      cmp("R7 card int", {31'h0, status_o[8]}, {31'h0, m_st[8]});
      cmp("R9 error summary", {31'h0, status_o[15]}, {31'h0, m_st[15]});
      cmp("R8 error bits", {18'h0, status_o[29:16]}, {18'h0, m_st[29:16]});
      cmp("R8 reserved", status_o & 32'hC000_7E0C, 32'h0);
      cmp("R10 irq", {31'h0, irq_o}, {31'h0, m_irq});
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      sw_rst = 0; cmd_wr = 0; rsp_done = 0; rsp_conflict = 0;
      err_evt = '0; stat_wr = 0; stat_wdata = '0;
    end
  endtask

  task automatic wclr(input logic [31:0] d);
    stat_wr = 1; stat_wdata = d; tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(2);
    phase = "R2 command flow";
    sig_en = 32'h1;
    cmd_wr = 1; tick(); tick(2);
    rsp_done = 1; tick(); tick(2);
    wclr(32'h1); tick();
    phase = "R12 conflict";
    cmd_wr = 1; tick();
    rsp_done = 1; rsp_conflict = 1; tick(); tick(2);
    rsp_done = 1; tick(); tick();
    phase = "R6 event wins over clear";
    cmd_wr = 1; tick();
    rsp_done = 1; stat_wr = 1; stat_wdata = 32'h1; tick(); tick();
    wclr(32'h0); tick();
    wclr(32'h1); tick();
    phase = "R3 data inhibit fall";
    sig_en = 32'h2;
    dat_line_act = 1; tick(2); rd_xfer_act = 1; tick(); dat_line_act = 0; tick(2);
    rd_xfer_act = 0; tick(2); wclr(32'h2);
    phase = "R5 buffer flags";
    buf_wr_ok = 1; tick(2); buf_rd_ok = 1; tick(2);
    buf_wr_ok = 0; buf_rd_ok = 0; tick(2); wclr(32'h30);
    phase = "R4 card presence";
    card_in = 1; card_stable = 1; tick(3); card_in = 0; tick(2); wclr(32'hC0);
    phase = "R7 card interrupt";
    card_irq = 1; sig_en = 32'h100; tick(2); wclr(32'h100); tick();
    stat_en[8] = 0; tick(2); stat_en[8] = 1; card_irq = 0; tick(2);
    phase = "R8 errors and R9 summary";
    sig_en = 32'h8000;
    err_evt = 14'h0001; tick(); err_evt = 14'h2000; tick(); tick();
    wclr(32'h0001_0000); tick(); wclr(32'h2000_8000); tick(2);
    phase = "R11 status enable";
    stat_en = 32'hFFFF_FFFE;
    cmd_wr = 1; tick(); rsp_done = 1; tick(); stat_en = '1; tick(2);
    stat_en = 32'h0; err_evt = 14'h3FFF; tick(); stat_en = '1; tick(2);
    phase = "R13 software reset";
    card_in = 1; tick(); cmd_wr = 1; err_evt = 14'h00F0; tick();
    sw_rst = 1; card_in = 0; card_stable = 0; tick(); tick(2);
    phase = "R10 random mix";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(7) == 0) dat_line_act = ~dat_line_act;
      if ($urandom_range(7) == 0) rd_xfer_act = ~rd_xfer_act;
      if ($urandom_range(9) == 0) buf_rd_ok = ~buf_rd_ok;
      if ($urandom_range(9) == 0) buf_wr_ok = ~buf_wr_ok;
      if ($urandom_range(15) == 0) card_in = ~card_in;
      if ($urandom_range(15) == 0) card_stable = ~card_stable;
      if ($urandom_range(11) == 0) card_irq = ~card_irq;
      cmd_wr = ($urandom_range(5) == 0);
      rsp_done = ($urandom_range(3) == 0);
      rsp_conflict = ($urandom_range(3) == 0);
      sw_rst = ($urandom_range(99) == 0);
      if ($urandom_range(5) == 0) err_evt = 14'($urandom);
      stat_wr = ($urandom_range(3) == 0);
      stat_wdata = $urandom;
      if ($urandom_range(31) == 0) stat_en = $urandom | 32'h0000_FFFF;
      if ($urandom_range(15) == 0) sig_en = $urandom;
      @(negedge clk);
    end
    tick(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule